// File: doc/BRIEF.md
# Fieldbus Slave Link-State Controller

This block is the data-link state machine of a slave node on a multi-drop master/slave fieldbus. Upstream logic hands it frames that are already decoded and CRC-checked, each with a destination address, a frame kind and the sender's receive/send sequence pair. The block decides whether the frame is meant for this node and tracks whether the node is disconnected or in normal response operation. It also keeps the node's own receive and send sequence counters. For every data frame it either accepts the payload, repeats its previous reply to a duplicate, or drops back to disconnected operation.

The controller presents at most one reply at a time on a valid/ready response port, and it stalls new frames until that reply is taken. Payload handling, bit coding and CRC are left to neighbouring blocks. They are told about an accepted payload by a one-cycle strobe.

Top module: `link_slave_ctrl`

## Requirements
- R1: After reset the node is disconnected (`mode_nrm`=0), both counters read 0, no reply is pending and `frm_ready` is 1.
- R2: A frame is acted on only if its destination equals `own_addr` or is 255 (broadcast). Destinations 0 and 250–254 are always ignored. If `own_addr` lies outside 1..249, every frame, broadcast included, is ignored.
- R3: While disconnected, a data frame (kind code 0) causes no reply, no payload strobe and no state change.
- R4: A mode-set frame (kind code 1) puts the node in response mode with both counters at 0. If it was addressed to the node, it raises an acknowledge reply (reply code 1) carrying 0/0. If it was broadcast, it raises no reply.
- R5: In response mode, a unicast data frame with received Ns equal to local Nr and received Nr equal to local Ns is in sequence. It strobes `pay_accept`, replies with code 0 carrying nr=Nr+1 and ns=old Ns, and increments both counters modulo 8.
- R6: In response mode, a unicast data frame with received Ns = Nr−1 and received Nr = Ns−1 (mod 8) is a duplicate. It strobes `err_recov`, resends the previous reply unchanged, gives no payload strobe and leaves the counters unchanged.
- R7: Any other sequence pair on a unicast data frame in response mode strobes `err_fatal`. The node returns to disconnected mode and replies with code 2 carrying 0/0, and the counters hold.
- R8: A broadcast data frame in response mode strobes `pay_accept`, raises no reply and leaves the counters unchanged, whatever its sequence pair.
- R9: Frame kind codes 2 and 3 are ignored in both modes.
- R10: While a reply is pending, `frm_ready` is 0 and the reply fields hold until `rsp_ready` is seen.
- R11: The counters and the mode change only in the cycle after a frame handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 8 | This node's address |
| frm_valid | input | 1 | Decoded frame present |
| frm_ready | output | 1 | Controller can take a frame |
| frm_dest | input | 8 | Destination address |
| frm_kind | input | 2 | 0 data, 1 mode-set, 2–3 unused |
| frm_nr | input | 3 | Sender's receive count |
| frm_ns | input | 3 | Sender's send count |
| rsp_valid | output | 1 | Reply pending |
| rsp_ready | input | 1 | Reply taken |
| rsp_kind | output | 2 | 0 ack-with-data, 1 mode acknowledge, 2 disconnected |
| rsp_nr | output | 3 | Receive count in reply |
| rsp_ns | output | 3 | Send count in reply |
| mode_nrm | output | 1 | 1 in response mode |
| seq_nr | output | 3 | Local next-expected count |
| seq_ns | output | 3 | Local send count |
| pay_accept | output | 1 | One-cycle payload-accepted strobe |
| err_recov | output | 1 | One-cycle duplicate strobe |
| err_fatal | output | 1 | One-cycle unrecoverable strobe |

## Verification
On every cycle the assertions check the response-port handshake and the reply holding steady under back-pressure. They also check that counters and mode stay put without a handshake, that counters read zero whenever response mode is entered, and that the strobes agree with the mode. Whether a given sequence pair is classed as in-sequence, duplicate or fatal, and whether the reply values and modulo-8 wrap are right, only the bench's reference model can show. It drives directed corner cases and seeded random frames. The same holds for the address filtering, including the invalid own-address case.

// File: rtl/link_pkg.sv
package link_pkg;
  typedef enum logic [1:0] {KIND_DATA = 2'd0, KIND_MODESET = 2'd1} frm_kind_e;
  typedef enum logic [1:0] {RSP_ACK = 2'd0, RSP_UA = 2'd1, RSP_DM = 2'd2} rsp_kind_e;
  typedef enum logic [1:0] {SEQ_OK, SEQ_DUP, SEQ_BAD} seq_res_e;
endpackage

// File: rtl/link_addr_filter.sv
module link_addr_filter #(
  parameter int ADDR_W   = 8,
  parameter int NODE_MIN = 1,
  parameter int NODE_MAX = 249,
  parameter int BCAST    = 255
) (
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] dest,
  output logic              hit_uni,
  output logic              hit_bc
);
  logic own_ok;
  always_comb begin
    own_ok  = (int'(own_addr) >= NODE_MIN) && (int'(own_addr) <= NODE_MAX);
    hit_uni = own_ok && (dest == own_addr);
    hit_bc  = own_ok && (int'(dest) == BCAST);
  end
endmodule

// File: rtl/link_seq_judge.sv
module link_seq_judge
  import link_pkg::*;
#(
  parameter int SEQ_W = 3
) (
  input  logic [SEQ_W-1:0] loc_nr,
  input  logic [SEQ_W-1:0] loc_ns,
  input  logic [SEQ_W-1:0] in_nr,
  input  logic [SEQ_W-1:0] in_ns,
  output seq_res_e         res
);
  localparam logic [SEQ_W-1:0] ONE = SEQ_W'(1);
  logic [SEQ_W-1:0] nr_prev, ns_prev;
  always_comb begin
    nr_prev = loc_nr - ONE;
    ns_prev = loc_ns - ONE;
    if (in_ns == loc_nr && in_nr == loc_ns)        res = SEQ_OK;
    else if (in_ns == nr_prev && in_nr == ns_prev) res = SEQ_DUP;
    else                                           res = SEQ_BAD;
  end
endmodule

// File: rtl/link_rsp_hold.sv
module link_rsp_hold
  import link_pkg::*;
#(
  parameter int SEQ_W = 3
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load,
  input  logic             resend,
  input  rsp_kind_e        new_kind,
  input  logic [SEQ_W-1:0] new_nr,
  input  logic [SEQ_W-1:0] new_ns,
  input  logic             rsp_ready,
  output logic             rsp_valid,
  output rsp_kind_e        rsp_kind,
  output logic [SEQ_W-1:0] rsp_nr,
  output logic [SEQ_W-1:0] rsp_ns
);
  logic             v_q, v_d;
  rsp_kind_e        k_q, k_d, lk_q, lk_d;
  logic [SEQ_W-1:0] nr_q, nr_d, ns_q, ns_d, lnr_q, lnr_d, lns_q, lns_d;

  always_comb begin
    v_d = v_q; k_d = k_q; nr_d = nr_q; ns_d = ns_q;
    lk_d = lk_q; lnr_d = lnr_q; lns_d = lns_q;
    if (v_q && rsp_ready) v_d = 1'b0;
    if (load) begin
      v_d = 1'b1; k_d = new_kind; nr_d = new_nr; ns_d = new_ns;
      lk_d = new_kind; lnr_d = new_nr; lns_d = new_ns;
    end else if (resend) begin
      v_d = 1'b1; k_d = lk_q; nr_d = lnr_q; ns_d = lns_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= 1'b0; k_q <= RSP_DM; nr_q <= '0; ns_q <= '0;
      lk_q <= RSP_DM; lnr_q <= '0; lns_q <= '0;
    end else begin
      v_q <= v_d; k_q <= k_d; nr_q <= nr_d; ns_q <= ns_d;
      lk_q <= lk_d; lnr_q <= lnr_d; lns_q <= lns_d;
    end
  end

  assign rsp_valid = v_q;
  assign rsp_kind  = k_q;
  assign rsp_nr    = nr_q;
  assign rsp_ns    = ns_q;
endmodule

// File: rtl/link_slave_ctrl.sv
module link_slave_ctrl
  import link_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SEQ_W    = 3,
  parameter int NODE_MIN = 1,
  parameter int NODE_MAX = 249,
  parameter int BCAST    = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [ADDR_W-1:0] frm_dest,
  input  logic [1:0]        frm_kind,
  input  logic [SEQ_W-1:0]  frm_nr,
  input  logic [SEQ_W-1:0]  frm_ns,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_kind,
  output logic [SEQ_W-1:0]  rsp_nr,
  output logic [SEQ_W-1:0]  rsp_ns,
  output logic              mode_nrm,
  output logic [SEQ_W-1:0]  seq_nr,
  output logic [SEQ_W-1:0]  seq_ns,
  output logic              pay_accept,
  output logic              err_recov,
  output logic              err_fatal
);
  localparam logic [SEQ_W-1:0] ONE = SEQ_W'(1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic       hit_uni, hit_bc;
  seq_res_e   seq_res;
  logic       take;
  logic       mode_q, mode_d;
  logic [SEQ_W-1:0] nr_q, nr_d, ns_q, ns_d;
  logic       pay_q, pay_d, rec_q, rec_d, fat_q, fat_d;
  logic       ld, rs;
  rsp_kind_e  ld_kind, rsp_kind_w;
  logic [SEQ_W-1:0] ld_nr, ld_ns;

  link_addr_filter #(.ADDR_W(ADDR_W), .NODE_MIN(NODE_MIN), .NODE_MAX(NODE_MAX), .BCAST(BCAST))
    u_filt (.own_addr(own_addr), .dest(frm_dest), .hit_uni(hit_uni), .hit_bc(hit_bc));

  link_seq_judge #(.SEQ_W(SEQ_W))
    u_judge (.loc_nr(nr_q), .loc_ns(ns_q), .in_nr(frm_nr), .in_ns(frm_ns), .res(seq_res));

  assign take = frm_valid && frm_ready;

  always_comb begin
    mode_d = mode_q; nr_d = nr_q; ns_d = ns_q;
    pay_d = 1'b0; rec_d = 1'b0; fat_d = 1'b0;
    ld = 1'b0; rs = 1'b0; ld_kind = RSP_DM; ld_nr = '0; ld_ns = '0;
    if (take && (hit_uni || hit_bc)) begin
      if (frm_kind == KIND_MODESET) begin
        mode_d = 1'b1; nr_d = '0; ns_d = '0;
        if (hit_uni) begin ld = 1'b1; ld_kind = RSP_UA; end
      end else if (frm_kind == KIND_DATA && mode_q) begin
        if (hit_bc) pay_d = 1'b1;
        else begin
          unique case (seq_res)
            SEQ_OK: begin
              pay_d = 1'b1; nr_d = nr_q + ONE; ns_d = ns_q + ONE;
              ld = 1'b1; ld_kind = RSP_ACK; ld_nr = nr_q + ONE; ld_ns = ns_q;
            end
            SEQ_DUP: begin rec_d = 1'b1; rs = 1'b1; end
            default: begin fat_d = 1'b1; mode_d = 1'b0; ld = 1'b1; ld_kind = RSP_DM; end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      mode_q <= 1'b0; nr_q <= '0; ns_q <= '0;
      pay_q <= 1'b0; rec_q <= 1'b0; fat_q <= 1'b0;
    end else begin
      mode_q <= mode_d; nr_q <= nr_d; ns_q <= ns_d;
      pay_q <= pay_d; rec_q <= rec_d; fat_q <= fat_d;
    end
  end

  link_rsp_hold #(.SEQ_W(SEQ_W)) u_rsp (
    .clk(clk), .rst_ni(rst_i), .load(ld), .resend(rs),
    .new_kind(ld_kind), .new_nr(ld_nr), .new_ns(ld_ns),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind_w),
    .rsp_nr(rsp_nr), .rsp_ns(rsp_ns));

  assign rsp_kind   = rsp_kind_w;
  assign frm_ready  = !rsp_valid;
  assign mode_nrm   = mode_q;
  assign seq_nr     = nr_q;
  assign seq_ns     = ns_q;
  assign pay_accept = pay_q;
  assign err_recov  = rec_q;
  assign err_fatal  = fat_q;
endmodule

// File: rtl/link_slave_chk.sv
module link_slave_chk #(
  parameter int SEQ_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid,
  input logic             frm_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [1:0]       rsp_kind,
  input logic [SEQ_W-1:0] rsp_nr,
  input logic [SEQ_W-1:0] rsp_ns,
  input logic             mode_nrm,
  input logic [SEQ_W-1:0] seq_nr,
  input logic [SEQ_W-1:0] seq_ns,
  input logic             pay_accept,
  input logic             err_recov,
  input logic             err_fatal
);
  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !frm_ready);
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_kind) && $stable(rsp_nr) && $stable(rsp_ns)));
  assert_quiet_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_valid && frm_ready) |=> ($stable(seq_nr) && $stable(seq_ns) && $stable(mode_nrm)));
  assert_enter_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_nrm) |-> (seq_nr == '0 && seq_ns == '0));
  assert_fatal_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_fatal |-> (!mode_nrm && rsp_valid && rsp_kind == 2'd2));
  assert_pay_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pay_accept |-> mode_nrm);
  assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pay_accept, err_recov, err_fatal}) <= 1);
endmodule

bind link_slave_ctrl link_slave_chk #(.SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
  .rsp_nr(rsp_nr), .rsp_ns(rsp_ns), .mode_nrm(mode_nrm), .seq_nr(seq_nr),
  .seq_ns(seq_ns), .pay_accept(pay_accept), .err_recov(err_recov), .err_fatal(err_fatal));

// File: tb/test_link_slave_ctrl.sv
module test_link_slave_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] own_addr = 8'd37;
  logic frm_valid = 1'b0, rsp_ready = 1'b0;
  logic [7:0] frm_dest = '0;
  logic [1:0] frm_kind = '0;
  logic [2:0] frm_nr = '0, frm_ns = '0;
  logic frm_ready, rsp_valid, mode_nrm, pay_accept, err_recov, err_fatal;
  logic [1:0] rsp_kind;
  logic [2:0] rsp_nr, rsp_ns, seq_nr, seq_ns;

  int errors = 0, checks = 0;

  // reference model state
  bit m_nrm = 0;
  logic [2:0] m_nr = 0, m_ns = 0, l_nr = 0, l_ns = 0;
  logic [1:0] l_kind = 2;

  link_slave_ctrl i_link_slave_ctrl (.*);

  always #5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit hit(logic [7:0] own, logic [7:0] d);
    if (own < 1 || own > 249) return 0;
    return (d == own) || (d == 8'd255);
  endfunction

  // 0 in sequence, 1 duplicate, 2 fatal
  function automatic int judge(logic [2:0] lnr, logic [2:0] lns, logic [2:0] inr, logic [2:0] ins);
    if (ins == lnr && inr == lns) return 0;
    if (ins == 3'(lnr - 3'd1) && inr == 3'(lns - 3'd1)) return 1;
    return 2;
  endfunction

  task automatic send(logic [7:0] d, logic [1:0] k, logic [2:0] nr, logic [2:0] ns,
                      string req, int hold);
    bit e_v = 0, e_pay = 0, e_rec = 0, e_fat = 0;
    logic [1:0] e_k = 0;
    logic [2:0] e_nr = 0, e_ns = 0;
    @(negedge clk);
    chk({req, " ready"}, frm_ready, 1);
    frm_valid = 1; frm_dest = d; frm_kind = k; frm_nr = nr; frm_ns = ns;
    if (hit(own_addr, d)) begin
      if (k == 2'd1) begin
        m_nrm = 1; m_nr = 0; m_ns = 0;
        if (d != 8'd255) begin e_v = 1; e_k = 1; l_kind = 1; l_nr = 0; l_ns = 0; end
      end else if (k == 2'd0 && m_nrm) begin
        if (d == 8'd255) e_pay = 1;
        else case (judge(m_nr, m_ns, nr, ns))
          0: begin
            e_pay = 1; e_v = 1; e_k = 0; e_nr = m_nr + 3'd1; e_ns = m_ns;
            l_kind = 0; l_nr = e_nr; l_ns = e_ns; m_nr++; m_ns++;
          end
          1: begin e_rec = 1; e_v = 1; e_k = l_kind; e_nr = l_nr; e_ns = l_ns; end
          default: begin e_fat = 1; m_nrm = 0; e_v = 1; e_k = 2; l_kind = 2; l_nr = 0; l_ns = 0; end
        endcase
      end
    end
    if (e_v) begin e_nr = l_nr; e_ns = l_ns; end
    @(negedge clk);
    frm_valid = 0;
    chk({req, " pay"}, pay_accept, e_pay);
    chk({req, " recov"}, err_recov, e_rec);
    chk({req, " fatal"}, err_fatal, e_fat);
    chk({req, " mode"}, mode_nrm, m_nrm);
    chk({req, " nr"}, seq_nr, m_nr);
    chk({req, " ns"}, seq_ns, m_ns);
    chk({req, " rsp_valid"}, rsp_valid, e_v);
    if (e_v) begin
      chk({req, " rsp_kind"}, rsp_kind, e_k);
      chk({req, " rsp_nr"}, rsp_nr, e_nr);
      chk({req, " rsp_ns"}, rsp_ns, e_ns);
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk("R10 stall ready", frm_ready, 0);
        chk("R10 hold kind", rsp_kind, e_k);
        chk("R10 hold nr", rsp_nr, e_nr);
      end
      rsp_ready = 1;
      @(negedge clk);
      rsp_ready = 0;
      chk({req, " rsp taken"}, rsp_valid, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1118));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 mode", mode_nrm, 0);
    chk("R1 nr", seq_nr, 0);
    chk("R1 ns", seq_ns, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 ready", frm_ready, 1);

    send(8'd37, 2'd0, 0, 0, "R3 data in disconnected", 0);
    send(8'd0,   2'd1, 0, 0, "R2 dest 0", 0);
    send(8'd250, 2'd1, 0, 0, "R2 dest 250", 0);
    send(8'd254, 2'd1, 0, 0, "R2 dest 254", 0);
    send(8'd38,  2'd1, 0, 0, "R2 other node", 0);
    send(8'd37, 2'd1, 5, 5, "R4 unicast mode-set", 0);
    send(8'd37, 2'd0, 7, 7, "R6 dup after mode-set", 0);
    for (int i = 0; i < 9; i++) send(8'd37, 2'd0, m_ns, m_nr, "R5 in sequence wrap", 0);
    send(8'd37, 2'd0, 3'(m_ns - 1), 3'(m_nr - 1), "R6 duplicate", 0);
    send(8'd255, 2'd0, 6, 2, "R8 broadcast data", 0);
    send(8'd37, 2'd2, m_ns, m_nr, "R9 kind 2", 0);
    send(8'd37, 2'd3, m_ns, m_nr, "R9 kind 3", 0);
    send(8'd37, 2'd0, m_ns, m_nr, "R10 back-pressure", 3);
    repeat (4) @(negedge clk);
    chk("R11 idle nr", seq_nr, m_nr);
    chk("R11 idle mode", mode_nrm, m_nrm);
    send(8'd37, 2'd0, m_ns, 3'(m_nr + 3), "R7 unrecoverable", 0);
    send(8'd37, 2'd0, m_ns, m_nr, "R3 data after fatal", 0);
    send(8'd255, 2'd1, 1, 1, "R4 broadcast mode-set", 0);

    for (int n = 0; n < 500; n++) begin
      int sel = $urandom_range(0, 9);
      logic [7:0] d;
      logic [1:0] k;
      logic [2:0] nr, ns;
      d = (sel < 6) ? 8'd37 : (sel == 6) ? 8'd255 : (sel == 7) ? 8'($urandom_range(250, 254)) : 8'($urandom);
      k = ($urandom_range(0, 9) == 0) ? 2'($urandom) : ($urandom_range(0, 7) == 0 ? 2'd1 : 2'd0);
      case ($urandom_range(0, 3))
        0, 1: begin nr = m_ns; ns = m_nr; end
        2: begin nr = 3'(m_ns - 1); ns = 3'(m_nr - 1); end
        default: begin nr = 3'($urandom); ns = 3'($urandom); end
      endcase
      send(d, k, nr, ns, "R11 random", $urandom_range(0, 1));
    end

    own_addr = 8'd250;
    send(8'd250, 2'd1, 0, 0, "R2 invalid own unicast", 0);
    send(8'd255, 2'd0, 0, 0, "R2 invalid own broadcast", 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule